// File: doc/BRIEF.md
# Multi-Core JTAG Debug Selector

This block is the test access port front end of a device that carries several processor cores, each with its own debug unit. It holds the usual sixteen-state TAP controller, a four-bit instruction register and two kinds of data register path. A dedicated choose instruction opens a selection scan that picks any subset of the cores. Once the choice is made, the selection stays put until the next choose scan. While it stands, the enable instruction threads the command registers of the picked cores into one serial chain between `tdi` and `tdo`. The debug-request instruction sends a one-TCK pulse to every picked core.

A host first runs the choose instruction and shifts one bit per core. It then issues enable and shifts the command words for all picked cores in a single scan. On Update-DR every picked core's command word is written in the same TCK edge. Debug requests can be raised at any time after the choice, as often as needed, and other instructions may be issued in between.

Top module: `jtag_core_selector`

## Requirements
- R1: An active-low `trstN` clears the block at once. Five consecutive TCK rising edges with `tms` high also clear it. After either reset, the controller is in Test-Logic-Reset, the instruction is BYPASS and `coreSelect` is all zeros.
- R2: The instruction register is 4 bits wide and shifts LSB first. It captures 4'b0001 in Capture-IR and takes the new code in Update-IR. The codes are BYPASS = 4'b1111, choose = 4'b0010, enable = 4'b0011 and debug-request = 4'b0100.
- R3: `tdo` and `tdoEn` change on the falling edge of `tck`. `tdoEn` is 1 only while the controller is in Shift-IR or Shift-DR. When `tdoEn` is 0, `tdo` is 0.
- R4: Under the choose instruction, the data path is an NCORES-bit selection register. Capture-DR loads the current selection into it, so a scan reads back the bits in the order they were written. `chooseActive` is 1 exactly during Shift-DR under the choose instruction.
- R5: The first bit shifted in during a choose scan lands in the cell nearest `tdo`, which is core NCORES-1. Shifting 1,0,0,0 with NCORES=4 selects core 3 alone (`coreSelect` = 4'b1000).
- R6: Several cores can be selected at once. Shifting 1,0,1,0 selects cores 1 and 3 (`coreSelect` = 4'b1010).
- R7: The selection changes only on Update-DR under the choose instruction, or on a reset. Other instructions and other scans leave it unchanged.
- R8: Under the enable instruction with at least one core selected, the data path is the CMDW-bit command registers of the selected cores only. They are chained in ascending core order, with core 0 nearest `tdi`, and each shifts LSB first. Capture-DR loads each selected core's current command word.
- R9: Update-DR under the enable instruction writes all selected cores' `coreCmd` words on the same edge. On the next TCK cycle it pulses `coreCmdStrobe` high for exactly those cores. Unselected cores keep their words and get no strobe.
- R10: Reaching Update-IR with the debug-request code raises `dbgReq` equal to `coreSelect` for exactly one TCK cycle. The pulse repeats each time the instruction is reissued, and no other instruction raises it.
- R11: Under BYPASS, under an unassigned code, or under enable with no core selected, the data path is a single flop that captures 0 in Capture-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trstN | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on falling edge |
| tdoEn | output | 1 | Output enable for tdo, high while shifting |
| chooseActive | output | 1 | High during the selection scan |
| coreSelect | output | NCORES | Sticky core selection, bit k for core k |
| coreCmd | output | NCORES*CMDW | Command word of each core, core k at bits k*CMDW+:CMDW |
| coreCmdStrobe | output | NCORES | One-cycle write strobe per core after Update-DR |
| dbgReq | output | NCORES | One-cycle debug request per selected core |

## Verification
The selection scan is driven with a single-bit pattern and a two-bit pattern. Together they separate the cell ordering from simple bit counting. Each pattern is read back to show that capture returns it in write order. The command chain is scanned with an asymmetric 16-bit word over two non-adjacent cores, which exposes any mix-up in chain order, in shift direction or in skipping the unselected cores. Bypass is tried under the BYPASS code, under an unassigned code and under enable with an empty selection. Each expects the input delayed by one bit behind a captured 0. Both reset routes are exercised after a live selection, and debug requests are issued repeatedly with other instructions in between.

// File: rtl/jcs_pkg.sv
`timescale 1ns/1ps
package jcs_pkg;
  typedef enum logic [3:0] {
    TLR, RTI, SEL_DR, CAP_DR, SH_DR, EX1_DR, PA_DR, EX2_DR, UPD_DR,
    SEL_IR, CAP_IR, SH_IR, EX1_IR, PA_IR, EX2_IR, UPD_IR
  } tapState_t;

  localparam int IR_W = 4;
  localparam logic [IR_W-1:0] IR_BYPASS  = 4'b1111;
  localparam logic [IR_W-1:0] IR_CHOOSE  = 4'b0010;
  localparam logic [IR_W-1:0] IR_ENABLE  = 4'b0011;
  localparam logic [IR_W-1:0] IR_DBGREQ  = 4'b0100;
  localparam logic [IR_W-1:0] IR_CAPTURE = 4'b0001;

  typedef struct packed {
    logic tlr;
    logic captureDr;
    logic shiftDr;
    logic updateDr;
    logic shiftIr;
    logic irOut;
    logic selChoose;
    logic selEnable;
    logic fireDbg;
  } strobes_t;
endpackage

// File: rtl/jcs_tap_ctrl.sv
`timescale 1ns/1ps
module jcs_tap_ctrl
  import jcs_pkg::*;
(
  input  logic     tck,
  input  logic     trstN,
  input  logic     tms,
  input  logic     tdi,
  output strobes_t strb
);
  tapState_t state, stateNext;
  logic [IR_W-1:0] irShift, irReg;

  always_comb begin
    stateNext = state;
    unique case (state)
      TLR:     stateNext = tms ? TLR    : RTI;
      RTI:     stateNext = tms ? SEL_DR : RTI;
      SEL_DR:  stateNext = tms ? SEL_IR : CAP_DR;
      CAP_DR:  stateNext = tms ? EX1_DR : SH_DR;
      SH_DR:   stateNext = tms ? EX1_DR : SH_DR;
      EX1_DR:  stateNext = tms ? UPD_DR : PA_DR;
      PA_DR:   stateNext = tms ? EX2_DR : PA_DR;
      EX2_DR:  stateNext = tms ? UPD_DR : SH_DR;
      UPD_DR:  stateNext = tms ? SEL_DR : RTI;
      SEL_IR:  stateNext = tms ? TLR    : CAP_IR;
      CAP_IR:  stateNext = tms ? EX1_IR : SH_IR;
      SH_IR:   stateNext = tms ? EX1_IR : SH_IR;
      EX1_IR:  stateNext = tms ? UPD_IR : PA_IR;
      PA_IR:   stateNext = tms ? EX2_IR : PA_IR;
      EX2_IR:  stateNext = tms ? UPD_IR : SH_IR;
      UPD_IR:  stateNext = tms ? SEL_DR : RTI;
      default: stateNext = TLR;
    endcase
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) state <= TLR;
    else        state <= stateNext;
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      irShift <= IR_CAPTURE;
      irReg   <= IR_BYPASS;
    end else begin
      case (state)
        TLR:    irReg   <= IR_BYPASS;
        CAP_IR: irShift <= IR_CAPTURE;
        SH_IR:  irShift <= {tdi, irShift[IR_W-1:1]};
        UPD_IR: irReg   <= irShift;
        default: ;
      endcase
    end
  end

  always_comb begin
    strb.tlr       = (state == TLR);
    strb.captureDr = (state == CAP_DR);
    strb.shiftDr   = (state == SH_DR);
    strb.updateDr  = (state == UPD_DR);
    strb.shiftIr   = (state == SH_IR);
    strb.irOut     = irShift[0];
    strb.selChoose = (irReg == IR_CHOOSE);
    strb.selEnable = (irReg == IR_ENABLE);
    strb.fireDbg   = (state == UPD_IR) && (irShift == IR_DBGREQ);
  end

  // independent count of consecutive TMS-high edges
  logic [2:0] tmsHighCnt;
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)    tmsHighCnt <= '0;
    else if (tms)  tmsHighCnt <= (tmsHighCnt == 3'd5) ? 3'd5 : tmsHighCnt + 3'd1;
    else           tmsHighCnt <= '0;
  end

  assert_five_tms_reset_R1: assert property (@(posedge tck) disable iff (!trstN)
    (tmsHighCnt == 3'd5) |-> (state == TLR));

  assert_tlr_bypass_R1: assert property (@(posedge tck) disable iff (!trstN)
    (state == TLR) |=> (irReg == IR_BYPASS));

  assert_ir_update_R2: assert property (@(posedge tck) disable iff (!trstN)
    (state == UPD_IR) |=> (irReg == $past(irShift)));
endmodule

// File: rtl/jcs_core_cell.sv
`timescale 1ns/1ps
module jcs_core_cell #(
  parameter int CMDW = 8
) (
  input  logic            tck,
  input  logic            trstN,
  input  logic            selected,
  input  logic            captureDr,
  input  logic            shiftDr,
  input  logic            updateDr,
  input  logic            serIn,
  output logic            serOut,
  output logic [CMDW-1:0] cmd,
  output logic            cmdStrobe
);
  logic [CMDW-1:0] shReg;

  assign serOut = shReg[0];

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      shReg     <= '0;
      cmd       <= '0;
      cmdStrobe <= 1'b0;
    end else begin
      cmdStrobe <= 1'b0;
      if (selected) begin
        if (captureDr)     shReg <= cmd;
        else if (shiftDr)  shReg <= {serIn, shReg[CMDW-1:1]};
        else if (updateDr) begin
          cmd       <= shReg;
          cmdStrobe <= 1'b1;
        end
      end
    end
  end

  assert_cmd_hold_R9: assert property (@(posedge tck) disable iff (!trstN)
    !(selected && updateDr) |=> $stable(cmd));
endmodule

// File: rtl/jcs_datapath.sv
`timescale 1ns/1ps
module jcs_datapath
  import jcs_pkg::*;
#(
  parameter int NCORES = 4,
  parameter int CMDW   = 8
) (
  input  logic                   tck,
  input  logic                   trstN,
  input  logic                   tdi,
  input  strobes_t               strb,
  output logic                   tdo,
  output logic                   tdoEn,
  output logic                   chooseActive,
  output logic [NCORES-1:0]      coreSelect,
  output logic [NCORES*CMDW-1:0] coreCmd,
  output logic [NCORES-1:0]      coreCmdStrobe,
  output logic [NCORES-1:0]      dbgReq
);
  localparam int LAST = NCORES - 1;

  logic [NCORES-1:0] selReg, selShift, cellOut;
  logic [NCORES:0]   link;
  logic              bypassFf, anySel, drOut;

  // selection register
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      selReg   <= '0;
      selShift <= '0;
    end else if (strb.tlr) begin
      selReg   <= '0;
    end else if (strb.selChoose) begin
      if (strb.captureDr)     selShift <= selReg;
      else if (strb.shiftDr)  selShift <= (selShift << 1) | NCORES'(tdi);
      else if (strb.updateDr) selReg   <= selShift;
    end
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)              bypassFf <= 1'b0;
    else if (strb.captureDr) bypassFf <= 1'b0;
    else if (strb.shiftDr)   bypassFf <= tdi;
  end

  // cascade of per-core command registers
  assign link[0] = tdi;
  for (genvar k = 0; k < NCORES; k++) begin : gCell
    jcs_core_cell #(.CMDW(CMDW)) uCell (
      .tck       (tck),
      .trstN     (trstN),
      .selected  (selReg[k]),
      .captureDr (strb.captureDr & strb.selEnable),
      .shiftDr   (strb.shiftDr & strb.selEnable),
      .updateDr  (strb.updateDr & strb.selEnable),
      .serIn     (link[k]),
      .serOut    (cellOut[k]),
      .cmd       (coreCmd[k*CMDW +: CMDW]),
      .cmdStrobe (coreCmdStrobe[k])
    );
    assign link[k+1] = selReg[k] ? cellOut[k] : link[k];
  end

  assign anySel = |selReg;

  always_comb begin
    if (strb.selChoose)                drOut = selShift[LAST];
    else if (strb.selEnable && anySel) drOut = link[NCORES];
    else                               drOut = bypassFf;
  end

  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN) begin
      tdo   <= 1'b0;
      tdoEn <= 1'b0;
    end else begin
      tdoEn <= strb.shiftDr | strb.shiftIr;
      tdo   <= strb.shiftIr ? strb.irOut : (strb.shiftDr ? drOut : 1'b0);
    end
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)            dbgReq <= '0;
    else if (strb.fireDbg) dbgReq <= selReg;
    else                   dbgReq <= '0;
  end

  assign coreSelect   = selReg;
  assign chooseActive = strb.selChoose & strb.shiftDr;

  assert_sel_persist_R7: assert property (@(posedge tck) disable iff (!trstN)
    (!(strb.updateDr && strb.selChoose) && !strb.tlr) |=> $stable(selReg));

  assert_tlr_clears_R1: assert property (@(posedge tck) disable iff (!trstN)
    strb.tlr |=> (selReg == '0));

  assert_dbg_single_R10: assert property (@(posedge tck) disable iff (!trstN)
    (|dbgReq) |=> (dbgReq == '0));

  assert_dbg_subset_R10: assert property (@(posedge tck) disable iff (!trstN)
    ((dbgReq & ~selReg) == '0));

  assert_strobe_subset_R9: assert property (@(posedge tck) disable iff (!trstN)
    ((coreCmdStrobe & ~selReg) == '0));

  assert_quiet_tdo_R3: assert property (@(posedge tck) disable iff (!trstN)
    !tdoEn |-> !tdo);
endmodule

// File: rtl/jtag_core_selector.sv
`timescale 1ns/1ps
module jtag_core_selector
  import jcs_pkg::*;
#(
  parameter int NCORES = 4,
  parameter int CMDW   = 8
) (
  input  logic                   tck,
  input  logic                   trstN,
  input  logic                   tms,
  input  logic                   tdi,
  output logic                   tdo,
  output logic                   tdoEn,
  output logic                   chooseActive,
  output logic [NCORES-1:0]      coreSelect,
  output logic [NCORES*CMDW-1:0] coreCmd,
  output logic [NCORES-1:0]      coreCmdStrobe,
  output logic [NCORES-1:0]      dbgReq
);
  strobes_t strb;

  jcs_tap_ctrl uCtrl (
    .tck   (tck),
    .trstN (trstN),
    .tms   (tms),
    .tdi   (tdi),
    .strb  (strb)
  );

  jcs_datapath #(.NCORES(NCORES), .CMDW(CMDW)) uPath (
    .tck           (tck),
    .trstN         (trstN),
    .tdi           (tdi),
    .strb          (strb),
    .tdo           (tdo),
    .tdoEn         (tdoEn),
    .chooseActive  (chooseActive),
    .coreSelect    (coreSelect),
    .coreCmd       (coreCmd),
    .coreCmdStrobe (coreCmdStrobe),
    .dbgReq        (dbgReq)
  );
endmodule

// File: tb/tb_jtag_core_selector.sv
`timescale 1ns/1ps
module tb_jtag_core_selector;
  localparam int NCORES = 4;
  localparam int CMDW   = 8;
  localparam logic [3:0] C_BYPASS = 4'b1111;
  localparam logic [3:0] C_CHOOSE = 4'b0010;
  localparam logic [3:0] C_ENABLE = 4'b0011;
  localparam logic [3:0] C_DBGREQ = 4'b0100;
  localparam logic [3:0] C_UNUSED = 4'b1010;

  logic tck = 1'b0, trstN = 1'b0, tms = 1'b0, tdi = 1'b0;
  logic tdo, tdoEn, chooseActive;
  logic [NCORES-1:0] coreSelect, coreCmdStrobe, dbgReq;
  logic [NCORES*CMDW-1:0] coreCmd;

  jtag_core_selector #(.NCORES(NCORES), .CMDW(CMDW)) dut (
    .tck(tck), .trstN(trstN), .tms(tms), .tdi(tdi), .tdo(tdo), .tdoEn(tdoEn),
    .chooseActive(chooseActive), .coreSelect(coreSelect), .coreCmd(coreCmd),
    .coreCmdStrobe(coreCmdStrobe), .dbgReq(dbgReq)
  );

  always #2 tck = ~tck;

  int nChecks = 0, nFail = 0;
  bit done = 1'b0;
  logic tdoS, enS, chooseS;
  logic enAll, chooseAll, enAfter, chooseAfter;
  logic [NCORES-1:0] dbgSeen, dbgAfter, strbSeen, strbAfter;
  logic [3:0] irCap;

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one TCK: drive after falling edge, sample tdo there, then wait rising edge
  task automatic tclk(input logic m, input logic d);
    @(negedge tck);
    #1;
    tdoS = tdo; enS = tdoEn; chooseS = chooseActive;
    tms = m; tdi = d;
    @(posedge tck);
  endtask

  task automatic scanIr(input logic [3:0] code);
    tclk(1, 0); tclk(1, 0); tclk(0, 0); tclk(0, 0);
    for (int i = 0; i < 4; i++) begin
      tclk(i == 3, code[i]);
      irCap[i] = tdoS;
    end
    tclk(1, 0);
    tclk(0, 0);
    #1 dbgSeen = dbgReq;
    tclk(0, 0);
    #1 dbgAfter = dbgReq;
  endtask

  task automatic scanDr(input logic [31:0] v, input int n, output logic [31:0] out);
    out = '0; enAll = 1'b1; chooseAll = 1'b1;
    tclk(1, 0); tclk(0, 0); tclk(0, 0);
    for (int i = 0; i < n; i++) begin
      tclk(i == n - 1, v[i]);
      out[i] = tdoS; enAll &= enS; chooseAll &= chooseS;
    end
    tclk(1, 0);
    tclk(0, 0);
    #1 strbSeen = coreCmdStrobe; enAfter = tdoEn; chooseAfter = chooseActive;
    tclk(0, 0);
    #1 strbAfter = coreCmdStrobe;
  endtask

  task automatic testReset();
    trstN = 1'b0; tms = 1'b0;
    repeat (3) @(posedge tck);
    #1;
    check("R1", "select at reset", 64'(coreSelect), 0);
    check("R1", "cmd at reset", 64'(coreCmd), 0);
    check("R1", "dbgReq at reset", 64'(dbgReq), 0);
    check("R3", "tdoEn at reset", 64'(tdoEn), 0);
    @(negedge tck); #1 trstN = 1'b1;
    tclk(0, 0);
  endtask

  task automatic testBypass();
    logic [31:0] o;
    scanIr(C_BYPASS);
    check("R2", "IR capture pattern", 64'(irCap), 64'h1);
    check("R10", "no request under BYPASS", 64'(dbgSeen), 0);
    scanDr(32'hB5, 9, o);
    check("R11", "bypass delay", 64'(o[8:0]), 64'h16A);
    check("R3", "tdoEn while shifting", 64'(enAll), 1);
    check("R3", "tdoEn after shift", 64'(enAfter), 0);
    scanIr(C_UNUSED);
    scanDr(32'h0C, 6, o);
    check("R11", "unassigned code bypass", 64'(o[5:0]), 64'h18);
  endtask

  task automatic testChooseSingle();
    logic [31:0] o;
    scanIr(C_CHOOSE);
    scanDr(32'b0001, 4, o);
    check("R5", "1,0,0,0 picks core nearest tdo", 64'(coreSelect), 64'b1000);
    check("R4", "chooseActive during shift", 64'(chooseAll), 1);
    check("R4", "chooseActive after shift", 64'(chooseAfter), 0);
    scanDr(32'b0001, 4, o);
    check("R4", "selection readback", 64'(o[3:0]), 64'b0001);
  endtask

  task automatic testChooseMulti();
    logic [31:0] o;
    scanDr(32'b0101, 4, o);
    check("R6", "1,0,1,0 picks two cores", 64'(coreSelect), 64'b1010);
    scanDr(32'b0101, 4, o);
    check("R4", "multi selection readback", 64'(o[3:0]), 64'b0101);
  endtask

  task automatic testEnableChain();
    logic [31:0] o;
    scanIr(C_ENABLE);
    check("R7", "select kept over enable", 64'(coreSelect), 64'b1010);
    scanDr(32'hA55C, 16, o);
    check("R8", "chain write order", 64'(coreCmd), 64'h5C00A500);
    check("R9", "strobes for selected", 64'(strbSeen), 64'b1010);
    check("R9", "strobe one cycle", 64'(strbAfter), 0);
    scanDr(32'h1234, 16, o);
    check("R8", "chain capture readback", 64'(o[15:0]), 64'hA55C);
    check("R9", "parallel update", 64'(coreCmd), 64'h34001200);
    check("R7", "select kept over DR scans", 64'(coreSelect), 64'b1010);
  endtask

  task automatic testDbgReq();
    scanIr(C_DBGREQ);
    check("R10", "request to selected", 64'(dbgSeen), 64'b1010);
    check("R10", "request single cycle", 64'(dbgAfter), 0);
    scanIr(C_BYPASS);
    check("R10", "no request for BYPASS", 64'(dbgSeen), 0);
    scanIr(C_DBGREQ);
    check("R10", "repeated request", 64'(dbgSeen), 64'b1010);
    check("R7", "select kept over requests", 64'(coreSelect), 64'b1010);
  endtask

  task automatic testNoSelection();
    logic [31:0] o;
    scanIr(C_CHOOSE);
    scanDr(32'b0000, 4, o);
    check("R7", "choose rewrites selection", 64'(coreSelect), 0);
    scanIr(C_ENABLE);
    scanDr(32'h2D, 7, o);
    check("R11", "enable with empty selection is bypass", 64'(o[6:0]), 64'h5A);
    check("R9", "no write with empty selection", 64'(coreCmd), 64'h34001200);
    check("R9", "no strobe with empty selection", 64'(strbSeen), 0);
  endtask

  task automatic testTmsReset();
    logic [31:0] o;
    scanIr(C_CHOOSE);
    scanDr(32'b0001, 4, o);
    check("R5", "reselect core 3", 64'(coreSelect), 64'b1000);
    repeat (5) tclk(1, 0);
    #1 check("R1", "five TMS-high clears selection", 64'(coreSelect), 0);
    tclk(0, 0);
    scanDr(32'h3, 3, o);
    check("R1", "instruction back to BYPASS", 64'(o[2:0]), 64'h6);
  endtask

  task automatic testTrst();
    logic [31:0] o;
    scanIr(C_CHOOSE);
    scanDr(32'b0101, 4, o);
    check("R6", "selection before trst", 64'(coreSelect), 64'b1010);
    @(negedge tck); trstN = 1'b0;
    #1 check("R1", "trst clears selection", 64'(coreSelect), 0);
    @(negedge tck); #1 trstN = 1'b1;
    tclk(0, 0);
  endtask

  initial begin
    #100000;
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    testReset();
    testBypass();
    testChooseSingle();
    testChooseMulti();
    testEnableChain();
    testDbgReq();
    testNoSelection();
    testTmsReset();
    testTrst();
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule